// File: doc/BRIEF.md
# Page ECC Parity Accumulator

This block sits beside a flash data path and builds a single-error-correcting Hamming code over every byte that passes. A page is split into segments of 256 bytes; each segment carries three code bytes made of line parity (which byte address holds the flipped bit) and column parity (which bit inside the byte). With the default of two segments, a 512-byte page yields six code bytes. Software compares these bytes against the ones stored in the spare area and repairs the data. The repair itself happens outside this block.

A two-bit mode input steers the accumulator. To start a page, software clears it, freezes it, and then enables accumulation. To fetch the result, it freezes, selects readout, and then freezes again. Bytes arrive on a valid/ready stream. The block raises `in_ready` only while it is accumulating and still has room in the page, so a byte counts exactly when `in_valid` and `in_ready` are both high. In every other mode, and once the page is full, the sender sees back-pressure.

In readout mode, `code_out` shows the byte under a read pointer. Each `rd_strobe` moves the pointer on to the next code byte.

Top module: `ecc_page_acc`

## Requirements
- R1: After reset the parity state is cleared, so a readout with no bytes accumulated returns 0xFF for all code bytes, and the read pointer is at its first position.
- R2: The mode input uses this encoding: 2'b11 clears, 2'b00 freezes, 2'b01 accumulates, and 2'b10 reads out.
- R3: `in_ready` is high only when the mode is 2'b01 and the page is not yet full. A byte is taken on a clock edge only when `in_valid` and `in_ready` are both high.
- R4: For a byte at segment address A whose bit parity is p, the block XORs p into line bit high[k] when A[k]=1 and into low[k] when A[k]=0, for k from 0 to 7. For each bit position b whose data bit is 1, it toggles column bit high[j] when b[j]=1 and low[j] when b[j]=0, for j from 0 to 2.
- R5: Code bytes are the inverted parity. Byte 0 is {h3,l3,h2,l2,h1,l1,h0,l0}, byte 1 is {h7,l7,h6,l6,h5,l5,h4,l4}, and byte 2 is {ch2,cl2,ch1,cl1,ch0,cl0,0,0}, all inverted. As a result, a page of 0xFF bytes reads back as all 0xFF.
- R6: The first 256 accepted bytes go to segment 0 and the next 256 go to segment 1. After NSEG×256 accepted bytes, `in_ready` stays low until the next clear.
- R7: Clear mode returns both the parity state and the byte counter to empty, so a following page is coded as if from reset.
- R8: In readout mode, successive strobed reads return segment 0 byte 1, byte 0, byte 2, and then the same three bytes of segment 1. After the last byte, the pointer wraps back to the first.
- R9: Each entry into readout mode resets the pointer. A strobe in the entry cycle reads the first code byte.
- R10: In freeze and readout modes, the parity state does not change, even when bytes are presented.
- R11: Outside readout mode, `code_out` is 0x00 and `rd_strobe` does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte ready (accumulating and page not full) |
| in_data | input | 8 | Stream byte |
| mode | input | 2 | 11 clear, 00 freeze, 01 accumulate, 10 readout |
| rd_strobe | input | 1 | Advance the read pointer in readout mode |
| code_out | output | 8 | Code byte under the read pointer; zero outside readout |

## Verification
Two events can land on the same clock cycle, and the bench provokes both.

The first is the cycle that enters readout. A strobe is raised in that same cycle, and the bench checks that the first byte seen is segment 0 byte 1 and that the second read moves on to byte 0.

The second is the hand-off between segments. A stimulus places nonzero bytes at addresses 255 and 256, so the counter wrap and the first segment-1 byte fall on consecutive edges. The bench then checks that each byte's parity lands in its own segment, using a bit-by-bit reference model.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_ACC   = 2'b01,
    MODE_READ  = 2'b10,
    MODE_CLEAR = 2'b11
  } ecc_mode_e;

  localparam int SEG_ADDR_W   = 8;
  localparam int BYTES_PER_SEG = 3;
  localparam int SEG_CODE_W   = 8 * BYTES_PER_SEG;

  // Bit-position masks: high half selects bits whose index has bit j set.
  function automatic logic [7:0] col_mask_hi(input int j);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = b[j];
    return m;
  endfunction
endpackage

// File: rtl/ecc_seg_counter.sv
module ecc_seg_counter #(
  parameter int NSEG = 2,
  localparam int CNT_W = $clog2(NSEG + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         take,
  output logic [ecc_pkg::SEG_ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]             seg,
  output logic                         full
);
  logic [ecc_pkg::SEG_ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]               seg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      seg_q  <= '0;
    end else if (clr) begin
      addr_q <= '0;
      seg_q  <= '0;
    end else if (take) begin
      addr_q <= addr_q + 1'b1;
      if (&addr_q) seg_q <= seg_q + 1'b1;
    end
  end

  assign addr = addr_q;
  assign seg  = seg_q;
  assign full = (seg_q == CNT_W'(NSEG));
endmodule

// File: rtl/ecc_seg_parity.sv
module ecc_seg_parity (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           en,
  input  logic [ecc_pkg::SEG_ADDR_W-1:0] addr,
  input  logic [7:0]                     data,
  output logic [ecc_pkg::SEG_CODE_W-1:0] code
);
  localparam int LP_W = 2 * ecc_pkg::SEG_ADDR_W;

  logic [LP_W-1:0] lp_q, lp_d;
  logic [5:0]      cp_q, cp_d;
  logic            bpar;

  always_comb begin
    bpar = ^data;
    lp_d = lp_q;
    cp_d = cp_q;
    for (int k = 0; k < ecc_pkg::SEG_ADDR_W; k++) begin
      lp_d[2*k+1] = lp_q[2*k+1] ^ (bpar &  addr[k]);
      lp_d[2*k]   = lp_q[2*k]   ^ (bpar & ~addr[k]);
    end
    for (int j = 0; j < 3; j++) begin
      cp_d[2*j+1] = cp_q[2*j+1] ^ (^(data &  ecc_pkg::col_mask_hi(j)));
      cp_d[2*j]   = cp_q[2*j]   ^ (^(data & ~ecc_pkg::col_mask_hi(j)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (clr) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (en) begin
      lp_q <= lp_d;
      cp_q <= cp_d;
    end
  end

  assign code = ~{cp_q, 2'b00, lp_q};
endmodule

// File: rtl/ecc_readout.sv
module ecc_readout #(
  parameter int NSEG = 2,
  localparam int SEG_PTR_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  ecc_pkg::ecc_mode_e                  mode,
  input  logic                                rd_strobe,
  input  logic [NSEG*ecc_pkg::SEG_CODE_W-1:0] codes,
  output logic [7:0]                          code_out,
  output logic [SEG_PTR_W-1:0]                rd_seg,
  output logic [1:0]                          rd_pos
);
  import ecc_pkg::*;

  ecc_mode_e            mode_q;
  logic [SEG_PTR_W-1:0] seg_q, seg_eff, seg_nxt;
  logic [1:0]           pos_q, pos_eff, pos_nxt;
  logic                 entering;
  int                   base;

  always_comb begin
    entering = (mode == MODE_READ) && (mode_q != MODE_READ);
    seg_eff  = entering ? '0 : seg_q;
    pos_eff  = entering ? '0 : pos_q;
    seg_nxt  = seg_eff;
    pos_nxt  = pos_eff;
    if (rd_strobe) begin
      if (pos_eff == 2'd2) begin
        pos_nxt = '0;
        seg_nxt = (seg_eff == SEG_PTR_W'(NSEG - 1)) ? '0 : seg_eff + 1'b1;
      end else begin
        pos_nxt = pos_eff + 1'b1;
      end
    end
    // Read order inside a segment: byte 1, byte 0, byte 2.
    base = int'(seg_eff) * SEG_CODE_W + ((pos_eff == 2'd0) ? 8 : (pos_eff == 2'd1) ? 0 : 16);
    code_out = (mode == MODE_READ) ? codes[base +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_HOLD;
      seg_q  <= '0;
      pos_q  <= '0;
    end else begin
      mode_q <= mode;
      if (mode == MODE_READ) begin
        seg_q <= seg_nxt;
        pos_q <= pos_nxt;
      end
    end
  end

  assign rd_seg = seg_q;
  assign rd_pos = pos_q;
endmodule

// File: rtl/ecc_page_acc.sv
module ecc_page_acc #(
  parameter int NSEG = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [1:0] mode,
  input  logic       rd_strobe,
  output logic [7:0] code_out
);
  import ecc_pkg::*;

  localparam int CNT_W     = $clog2(NSEG + 1);
  localparam int SEG_PTR_W = (NSEG > 1) ? $clog2(NSEG) : 1;

  ecc_mode_e                  mode_e;
  logic                       clr, take, full;
  logic [SEG_ADDR_W-1:0]      addr;
  logic [CNT_W-1:0]           seg;
  logic [NSEG*SEG_CODE_W-1:0] page_code;
  logic [SEG_PTR_W-1:0]       rd_seg;
  logic [1:0]                 rd_pos;

  assign mode_e   = ecc_mode_e'(mode);
  assign clr      = (mode_e == MODE_CLEAR);
  assign in_ready = (mode_e == MODE_ACC) && !full;
  assign take     = in_valid && in_ready;

  ecc_seg_counter #(.NSEG(NSEG)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take),
    .addr(addr), .seg(seg), .full(full)
  );

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    ecc_seg_parity u_par (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .en(take && (seg == CNT_W'(i))),
      .addr(addr), .data(in_data),
      .code(page_code[i*SEG_CODE_W +: SEG_CODE_W])
    );
  end

  ecc_readout #(.NSEG(NSEG)) u_rd (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .rd_strobe(rd_strobe),
    .codes(page_code), .code_out(code_out), .rd_seg(rd_seg), .rd_pos(rd_pos)
  );
endmodule

// File: rtl/ecc_page_acc_chk.sv
module ecc_page_acc_chk #(
  parameter int NSEG = 2,
  parameter int SEG_PTR_W = 1
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [1:0]                          mode,
  input logic                                in_ready,
  input logic [7:0]                          code_out,
  input logic [NSEG*ecc_pkg::SEG_CODE_W-1:0] page_code,
  input logic [SEG_PTR_W-1:0]                rd_seg,
  input logic [1:0]                          rd_pos
);
  assert_ready_only_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> mode == 2'b01);

  assert_clear_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> &page_code);

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b10) |=> $stable(page_code));

  assert_ptr_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b10 |=> $stable({rd_seg, rd_pos}));

  assert_ptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pos != 2'd3 && int'(rd_seg) < NSEG);

  assert_entry_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) != 2'b10) |-> code_out == page_code[15:8]);
endmodule

bind ecc_page_acc ecc_page_acc_chk #(.NSEG(NSEG), .SEG_PTR_W(SEG_PTR_W)) chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .in_ready(in_ready),
  .code_out(code_out), .page_code(page_code), .rd_seg(rd_seg), .rd_pos(rd_pos)
);

// File: tb/ecc_page_acc_test.sv
module ecc_page_acc_test;
  localparam int NSEG = 2;
  localparam int PAGE = NSEG * 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [1:0] mode = 2'b00;
  logic       rd_strobe = 1'b0;
  logic [7:0] code_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] page [PAGE];
  logic [7:0] exp_rd [3*NSEG];

  // Stimulus vectors: {kind, arg}. 0 constant, 1 scrambled, 2 single bits, 3 boundary
  localparam logic [9:0] VEC [5] = '{10'h0FF, {2'd1, 8'h3C}, {2'd2, 8'h00},
                                    {2'd2, 8'hA7}, {2'd3, 8'h00}};

  ecc_page_acc #(.NSEG(NSEG)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .mode(mode), .rd_strobe(rd_strobe), .code_out(code_out)
  );

  always #4 clk = ~clk;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_seg(input int s);
    logic [7:0] h, l;
    logic [2:0] ch, cl;
    logic [7:0] b0, b1, b2;
    h = '0; l = '0; ch = '0; cl = '0;
    for (int i = 0; i < 256; i++)
      for (int b = 0; b < 8; b++)
        if (page[s*256+i][b]) begin
          for (int k = 0; k < 8; k++) if (i[k]) h[k] = ~h[k]; else l[k] = ~l[k];
          for (int j = 0; j < 3; j++) if (b[j]) ch[j] = ~ch[j]; else cl[j] = ~cl[j];
        end
    b0 = ~{h[3], l[3], h[2], l[2], h[1], l[1], h[0], l[0]};
    b1 = ~{h[7], l[7], h[6], l[6], h[5], l[5], h[4], l[4]};
    b2 = ~{ch[2], cl[2], ch[1], cl[1], ch[0], cl[0], 2'b00};
    return {b2, b1, b0};
  endfunction

  task automatic build_exp();
    for (int s = 0; s < NSEG; s++) begin
      logic [23:0] c;
      c = model_seg(s);
      exp_rd[3*s]   = c[15:8];
      exp_rd[3*s+1] = c[7:0];
      exp_rd[3*s+2] = c[23:16];
    end
  endtask

  task automatic fill(input logic [1:0] kind, input logic [7:0] arg);
    for (int i = 0; i < PAGE; i++) begin
      case (kind)
        2'd0: page[i] = arg;
        2'd1: page[i] = 8'((i * 7) ^ arg ^ (i >> 8));
        2'd2: page[i] = (i == int'(arg)) ? 8'h80 : (i == 256 + int'(arg)) ? 8'h01 : 8'h00;
        default: page[i] = (i == 255) ? 8'h01 : (i == 256) ? 8'h02 : 8'h00;
      endcase
    end
  endtask

  task automatic start_page();
    @(negedge clk) mode = 2'b11;
    @(negedge clk) mode = 2'b00;
    @(negedge clk) mode = 2'b01;
  endtask

  task automatic push(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = page[i];
      if (i == 0) begin
        #1 check8(req, {7'd0, in_ready}, 8'h01);
      end
    end
    @(negedge clk) in_valid = 1'b0;
    mode = 2'b00;
  endtask

  task automatic read_all(input string req);
    @(negedge clk) mode = 2'b00;
    @(negedge clk) begin mode = 2'b10; rd_strobe = 1'b1; end
    for (int j = 0; j < 3*NSEG; j++) begin
      #1 check8(req, code_out, exp_rd[j]);
      @(negedge clk);
    end
    rd_strobe = 1'b0;
    mode = 2'b00;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R11 / R3: reset state
    #1 check8("R11 idle output", code_out, 8'h00);
    check8("R3 ready in hold", {7'd0, in_ready}, 8'h00);
    fill(2'd0, 8'hFF);
    build_exp();
    read_all("R1 reset readout");

    // Table of vectors: R2 R4 R5 R6 R8
    for (int v = 0; v < 5; v++) begin
      fill(VEC[v][9:8], VEC[v][7:0]);
      build_exp();
      start_page();
      push(PAGE, "R2 R3 accumulate ready");
      read_all(v == 0 ? "R5 erased page" : (v == 4 ? "R6 segment boundary" : "R4 R8 parity order"));
    end

    // R6: page full blocks further bytes
    @(negedge clk) mode = 2'b01;
    #1 check8("R6 full not ready", {7'd0, in_ready}, 8'h00);
    @(negedge clk) begin in_valid = 1'b1; in_data = 8'h5A; end
    repeat (3) @(negedge clk);
    in_valid = 1'b0; mode = 2'b00;
    read_all("R6 extra bytes ignored");

    // R10: hold mode ignores presented bytes
    @(negedge clk) begin mode = 2'b00; in_valid = 1'b1; in_data = 8'h33; end
    #1 check8("R10 hold not ready", {7'd0, in_ready}, 8'h00);
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    read_all("R10 hold unchanged");

    // R9 / R11 / R8 wrap: pointer behaviour
    @(negedge clk) begin mode = 2'b10; rd_strobe = 1'b1; end
    #1 check8("R9 entry read", code_out, exp_rd[0]);
    @(negedge clk);
    #1 check8("R9 second read", code_out, exp_rd[1]);
    @(negedge clk) begin mode = 2'b00; rd_strobe = 1'b1; end
    #1 check8("R11 zero outside readout", code_out, 8'h00);
    repeat (3) @(negedge clk);
    mode = 2'b10; rd_strobe = 1'b0;
    #1 check8("R9 re-entry resets pointer", code_out, exp_rd[0]);
    @(negedge clk) rd_strobe = 1'b1;
    for (int j = 0; j < 3*NSEG; j++) @(negedge clk);
    #1 check8("R8 wrap to first", code_out, exp_rd[0]);
    @(negedge clk) begin rd_strobe = 1'b0; mode = 2'b00; end

    // R7: clear drops a partial page and its count
    fill(2'd0, 8'h11);
    start_page();
    push(100, "R7 partial start");
    fill(2'd1, 8'h81);
    build_exp();
    start_page();
    push(PAGE, "R7 restart ready");
    read_all("R7 clear restarts page");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule